// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block turns single register requests from an on-chip requester into the access sequence that an external peripheral with a 16-bit multiplexed register bus expects. The peripheral has two strobes: one selects its index register and one selects its data register. It also has a read enable, a write enable and one bidirectional 16-bit data bus. Every request starts by writing a register index into the index register. One or two data-register accesses follow. For a 32-bit request the data travels as two half-words.

The requester presents an 8-bit register index, a write flag, a width flag (16 or 32 bits) and up to 32 bits of write data under a valid/ready handshake. The bridge accepts one request at a time and holds ready low until that request completes. It counts clock cycles to keep the peripheral's minimum idle time after the index phase and between data accesses. It ends each request with a one-cycle done pulse. For reads, the assembled word is valid at that pulse. The idle times are given in nanoseconds and are turned into cycle counts from the clock period at elaboration.

Top module: `regbus_bridge`

## Requirements
- R1: Each request starts with exactly one index-phase strobe (`pb_addr_sel`) with `pb_wr` high and `pb_rd` low. The bus carries the index in bits 7:0, and bits 15:8 are zero. On a write request, bit 7 of the driven index is forced to 1. On a read request, the index is driven unchanged.
- R2: A 16-bit request performs exactly one data strobe (`pb_data_sel`). On a write, that strobe carries `req_wdata[15:0]`.
- R3: A 32-bit request performs exactly two data strobes. On a write, the first carries `req_wdata[15:0]` and the second carries `req_wdata[31:16]`.
- R4: On a 32-bit read, the word read in the first data strobe lands in `rsp_rdata[15:0]` and the second lands in `rsp_rdata[31:16]`. On a 16-bit read, `rsp_rdata[31:16]` is zero.
- R5: Between the end of an index strobe and the start of the next data strobe there are at least ceil(ADDR_GAP_NS / CLK_PERIOD_NS) clock cycles with no strobe active.
- R6: Between the end of a data strobe and the start of the next strobe of any kind there are at least ceil(DATA_GAP_NS / CLK_PERIOD_NS) idle cycles. This applies also when the next strobe belongs to the next request.
- R7: While no strobe is active, `pb_rd` and `pb_wr` are low and the bridge does not drive the bus.
- R8: Every strobe lasts exactly STROBE_CYC cycles. During a write strobe the bus is driven with a value that stays constant for the whole strobe. During a read strobe the bridge does not drive the bus.
- R9: After a request is accepted, `req_ready` stays low until the done pulse. `rsp_done` is high for exactly one cycle per request.
- R10: After reset, `req_ready` is high, and `rsp_done`, both strobes, `pb_rd` and `pb_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_index | input | 8 | Peripheral register index |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_done` |
| pb_addr_sel | output | 1 | Index-register strobe |
| pb_data_sel | output | 1 | Data-register strobe |
| pb_rd | output | 1 | Peripheral read enable |
| pb_wr | output | 1 | Peripheral write enable |
| pb_data | inout | 16 | Multiplexed index/data bus |

## Verification
The hardest case to reach is a new request arriving while the previous one is still ending. In that case the idle time after the last data strobe must be enforced across the request boundary, before the next index phase. The bench raises the next request at the first falling edge after the done pulse, so every transaction of the sweep meets a bridge that must hold ready low for the remaining idle cycles. A timestamped peripheral model measures each gap. The sweep covers all 128 low indices with alternating widths and directions. Each 32-bit write is read back in full, and each 16-bit write is read back on its own, so a swapped half-word or a lost direction flag shows up as a data mismatch.

// File: rtl/brg_pkg.sv
package brg_pkg;

  localparam int unsigned HALF_W = 16;
  localparam int unsigned IDX_W  = 8;

  // direction marker merged into the index during the index phase
  localparam logic [IDX_W-1:0] WRITE_FLAG = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_GAP,
    ST_DATA_LO,
    ST_DATA_GAP,
    ST_DATA_HI,
    ST_DONE
  } brg_state_e;

  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

endpackage

// File: rtl/brg_gap_timer.sv
// Counts idle cycles since the last strobe cycle and reports whether
// each of the two spacing limits has been met.
module brg_gap_timer #(
  parameter int unsigned ADDR_GAP_CYC = 75,
  parameter int unsigned DATA_GAP_CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_on,
  output logic addr_gap_ok,
  output logic data_gap_ok
);

  localparam int unsigned SAT = (ADDR_GAP_CYC > DATA_GAP_CYC) ? ADDR_GAP_CYC : DATA_GAP_CYC;
  localparam int unsigned CW  = $clog2(SAT + 1);

  logic [CW-1:0] idle_q;
  logic [CW-1:0] idle_d;
  logic          idle_en;

  always_comb begin
    idle_en = strobe_on || (idle_q != CW'(SAT));
    idle_d  = strobe_on ? '0 : idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= CW'(SAT);
    end else if (idle_en) begin
      idle_q <= idle_d;
    end
  end

  // met when the next cycle may start a strobe
  assign addr_gap_ok = (32'(idle_q) + 32'd1) >= ADDR_GAP_CYC;
  assign data_gap_ok = (32'(idle_q) + 32'd1) >= DATA_GAP_CYC;

endmodule

// File: rtl/brg_sequencer.sv
// Request sequencing: index phase, spacing, one or two data phases, done.
module brg_sequencer
  import brg_pkg::*;
#(
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_wide,
  input  logic addr_gap_ok,
  input  logic data_gap_ok,
  output logic req_ready,
  output logic accept,
  output logic strobe_on,
  output logic ph_addr,
  output logic ph_lo,
  output logic ph_hi,
  output logic cap_lo,
  output logic cap_hi,
  output logic pb_rd,
  output logic pb_wr,
  output logic done
);

  localparam int unsigned PW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

  brg_state_e    state_q, state_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_en;
  logic          strobe_last;
  logic          write_q, wide_q;

  assign req_ready   = (state_q == ST_IDLE) && data_gap_ok;
  assign accept      = req_valid && req_ready;
  assign ph_addr     = (state_q == ST_ADDR);
  assign ph_lo       = (state_q == ST_DATA_LO);
  assign ph_hi       = (state_q == ST_DATA_HI);
  assign strobe_on   = ph_addr || ph_lo || ph_hi;
  assign strobe_last = (pcnt_q == PW'(STROBE_CYC - 1));
  assign cap_lo      = ph_lo && strobe_last && !write_q;
  assign cap_hi      = ph_hi && strobe_last && !write_q;
  assign pb_wr       = ph_addr || ((ph_lo || ph_hi) && write_q);
  assign pb_rd       = (ph_lo || ph_hi) && !write_q;
  assign done        = (state_q == ST_DONE);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept)      state_d = ST_ADDR;
      ST_ADDR:     if (strobe_last) state_d = ST_ADDR_GAP;
      ST_ADDR_GAP: if (addr_gap_ok) state_d = ST_DATA_LO;
      ST_DATA_LO:  if (strobe_last) state_d = wide_q ? ST_DATA_GAP : ST_DONE;
      ST_DATA_GAP: if (data_gap_ok) state_d = ST_DATA_HI;
      ST_DATA_HI:  if (strobe_last) state_d = ST_DONE;
      ST_DONE:                      state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  // strobe width counter
  always_comb begin
    pcnt_en = strobe_on;
    pcnt_d  = strobe_last ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      wide_q  <= 1'b0;
    end else if (accept) begin
      write_q <= req_write;
      wide_q  <= req_wide;
    end
  end

endmodule

// File: rtl/brg_datapath.sv
// Holds the request, forms the bus value for each phase and assembles
// read half-words.
module brg_datapath
  import brg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                req_write,
  input  logic [IDX_W-1:0]    req_index,
  input  logic [2*HALF_W-1:0] req_wdata,
  input  logic                ph_addr,
  input  logic                ph_lo,
  input  logic                ph_hi,
  input  logic                cap_lo,
  input  logic                cap_hi,
  input  logic [HALF_W-1:0]   bus_in,
  output logic [HALF_W-1:0]   bus_out,
  output logic                bus_oe,
  output logic [2*HALF_W-1:0] rdata
);

  logic [IDX_W-1:0]    idx_q;
  logic                wr_q;
  logic [2*HALF_W-1:0] wdata_q;
  logic [1:0]          cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      idx_q   <= req_index;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    if (ph_addr) begin
      bus_out = {{(HALF_W-IDX_W){1'b0}}, idx_q | (wr_q ? WRITE_FLAG : '0)};
    end else if (ph_hi) begin
      bus_out = wdata_q[2*HALF_W-1:HALF_W];
    end else begin
      bus_out = wdata_q[HALF_W-1:0];
    end
  end

  assign bus_oe = ph_addr || ((ph_lo || ph_hi) && wr_q);
  assign cap    = {cap_hi, cap_lo};

  // one capture register per half-word
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[h*HALF_W +: HALF_W] <= '0;
      end else if (accept) begin
        rdata[h*HALF_W +: HALF_W] <= '0;
      end else if (cap[h]) begin
        rdata[h*HALF_W +: HALF_W] <= bus_in;
      end
    end
  end

endmodule

// File: rtl/regbus_bridge.sv
module regbus_bridge
  import brg_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned ADDR_GAP_NS   = 300,
  parameter int unsigned DATA_GAP_NS   = 150,
  parameter int unsigned STROBE_CYC    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_wide,
  input  logic [7:0]  req_index,
  input  logic [31:0] req_wdata,
  output logic        rsp_done,
  output logic [31:0] rsp_rdata,
  output logic        pb_addr_sel,
  output logic        pb_data_sel,
  output logic        pb_rd,
  output logic        pb_wr,
  inout  wire  [15:0] pb_data
);

  localparam int unsigned ADDR_GAP_CYC = ns_to_cycles(ADDR_GAP_NS, CLK_PERIOD_NS);
  localparam int unsigned DATA_GAP_CYC = ns_to_cycles(DATA_GAP_NS, CLK_PERIOD_NS);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              addr_gap_ok, data_gap_ok;
  logic              accept, strobe_on;
  logic              ph_addr, ph_lo, ph_hi, cap_lo, cap_hi;
  logic [HALF_W-1:0] bus_out;
  logic              bus_oe;

  // reset: asserted at once, removed on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  brg_gap_timer #(
    .ADDR_GAP_CYC(ADDR_GAP_CYC),
    .DATA_GAP_CYC(DATA_GAP_CYC)
  ) u_gap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .strobe_on  (strobe_on),
    .addr_gap_ok(addr_gap_ok),
    .data_gap_ok(data_gap_ok)
  );

  brg_sequencer #(
    .STROBE_CYC(STROBE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_wide   (req_wide),
    .addr_gap_ok(addr_gap_ok),
    .data_gap_ok(data_gap_ok),
    .req_ready  (req_ready),
    .accept     (accept),
    .strobe_on  (strobe_on),
    .ph_addr    (ph_addr),
    .ph_lo      (ph_lo),
    .ph_hi      (ph_hi),
    .cap_lo     (cap_lo),
    .cap_hi     (cap_hi),
    .pb_rd      (pb_rd),
    .pb_wr      (pb_wr),
    .done       (rsp_done)
  );

  brg_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .accept   (accept),
    .req_write(req_write),
    .req_index(req_index),
    .req_wdata(req_wdata),
    .ph_addr  (ph_addr),
    .ph_lo    (ph_lo),
    .ph_hi    (ph_hi),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .bus_in   (pb_data),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .rdata    (rsp_rdata)
  );

  assign pb_addr_sel = ph_addr;
  assign pb_data_sel = ph_lo || ph_hi;
  assign pb_data     = bus_oe ? bus_out : 16'hzzzz;

endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int unsigned ADDR_GAP_CYC = 75,
  parameter int unsigned DATA_GAP_CYC = 38,
  parameter int unsigned STROBE_CYC   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic pb_addr_sel,
  input logic pb_data_sel,
  input logic pb_rd,
  input logic pb_wr,
  input logic bus_oe
);

  localparam int unsigned SAT = (ADDR_GAP_CYC > DATA_GAP_CYC) ? ADDR_GAP_CYC : DATA_GAP_CYC;

  logic        strobe_now, strobe_prev, last_addr_q;
  int unsigned idle_q, width_q;

  assign strobe_now = pb_addr_sel || pb_data_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev <= 1'b0;
      last_addr_q <= 1'b0;
      idle_q      <= SAT;
      width_q     <= 0;
    end else begin
      strobe_prev <= strobe_now;
      width_q     <= strobe_now ? width_q + 1 : 0;
      if (strobe_now) begin
        idle_q      <= 0;
        last_addr_q <= pb_addr_sel;
      end else if (idle_q < SAT) begin
        idle_q <= idle_q + 1;
      end
    end
  end

  p_addr_phase_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pb_addr_sel |-> (pb_wr && !pb_rd && !pb_data_sel));

  p_addr_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_now && !strobe_prev && last_addr_q) |-> (idle_q >= ADDR_GAP_CYC));

  p_data_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_now && !strobe_prev && !last_addr_q) |-> (idle_q >= DATA_GAP_CYC));

  p_quiet_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_now |-> (!pb_rd && !pb_wr && !bus_oe));

  p_strobe_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_prev && !strobe_now) |-> (width_q == STROBE_CYC));

  p_read_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pb_rd |-> !bus_oe);

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

bind regbus_bridge brg_checker #(
  .ADDR_GAP_CYC(ADDR_GAP_CYC),
  .DATA_GAP_CYC(DATA_GAP_CYC),
  .STROBE_CYC  (STROBE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .pb_addr_sel(pb_addr_sel),
  .pb_data_sel(pb_data_sel),
  .pb_rd      (pb_rd),
  .pb_wr      (pb_wr),
  .bus_oe     (bus_oe)
);

// File: tb/tb_regbus_bridge.sv
`timescale 1ns/1ps
module tb_regbus_bridge;

  localparam int unsigned PERIOD = 4;
  localparam int unsigned STROBE = 2;
  localparam int unsigned AG     = (300 + PERIOD - 1) / PERIOD;
  localparam int unsigned DG     = (150 + PERIOD - 1) / PERIOD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_wide;
  logic [7:0]  req_index;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_done;
  logic [31:0] rsp_rdata;
  logic        pb_addr_sel, pb_data_sel, pb_rd, pb_wr;
  wire  [15:0] pb_data;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  regbus_bridge #(
    .CLK_PERIOD_NS(PERIOD),
    .ADDR_GAP_NS  (300),
    .DATA_GAP_NS  (150),
    .STROBE_CYC   (STROBE)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wide(req_wide), .req_index(req_index), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .pb_addr_sel(pb_addr_sel), .pb_data_sel(pb_data_sel),
    .pb_rd(pb_rd), .pb_wr(pb_wr), .pb_data(pb_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- peripheral model ----------------
  logic [31:0] regs [128];
  logic [6:0]  cur_reg = '0;
  bit          half_ptr = 1'b0;
  logic [15:0] model_rd;
  int unsigned cyc = 0;
  bit          mon_en = 1'b0;
  bit          prev_any = 1'b0, have_prev = 1'b0, last_was_addr = 1'b0, gap_dirty = 1'b0;
  bit          cur_is_data = 1'b0;
  int unsigned last_end = 0, width = 0, data_cnt = 0;
  logic [15:0] addr_word = '0, strobe_val = '0;

  assign model_rd = half_ptr ? regs[cur_reg][31:16] : regs[cur_reg][15:0];
  assign pb_data  = pb_rd ? model_rd : 16'hzzzz;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (mon_en) begin
      bit any;
      any = pb_addr_sel || pb_data_sel;
      if (any && !prev_any) begin
        if (have_prev) begin
          if (last_was_addr)
            chk(cyc - last_end - 1 >= AG, "R5 index-to-data gap", cyc - last_end - 1, AG);
          else
            chk(cyc - last_end - 1 >= DG, "R6 data-to-next gap", cyc - last_end - 1, DG);
        end
        chk(!gap_dirty, "R7 enable active outside strobe", 32'(gap_dirty), 0);
        gap_dirty  = 1'b0;
        strobe_val = pb_data;
        cur_is_data = pb_data_sel;
        if (pb_addr_sel) begin
          chk(pb_wr && !pb_rd && !pb_data_sel, "R1 index phase is a write",
              {29'd0, pb_wr, pb_rd, pb_data_sel}, 32'h4);
          addr_word = pb_data;
          cur_reg   = pb_data[6:0];
          half_ptr  = 1'b0;
          data_cnt  = 0;
        end else begin
          data_cnt++;
          if (pb_wr) begin
            if (half_ptr) regs[cur_reg][31:16] = pb_data;
            else          regs[cur_reg][15:0]  = pb_data;
          end
        end
      end
      if (any) begin
        if (pb_wr && prev_any)
          chk(pb_data == strobe_val, "R8 write data stable in strobe", {16'd0, pb_data}, {16'd0, strobe_val});
        width++;
        last_end      = cyc;
        last_was_addr = pb_addr_sel;
        have_prev     = 1'b1;
      end else begin
        if (pb_rd || pb_wr) gap_dirty = 1'b1;
        if (prev_any) begin
          chk(width == STROBE, "R8 strobe width", width, STROBE);
          if (cur_is_data) half_ptr = ~half_ptr;
          width = 0;
        end
      end
      prev_any = any;
    end
  end

  // ---------------- request driver ----------------
  task automatic xfer(input bit wr, input bit wide, input logic [7:0] idx,
                      input logic [31:0] wd, output logic [31:0] rd);
    bit ready_seen;
    int unsigned n;
    req_write = wr; req_wide = wide; req_index = idx; req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid  = 1'b0;
    ready_seen = 1'b0;
    n = 0;
    while (!rsp_done && n < 2000) begin
      if (req_ready) ready_seen = 1'b1;
      @(negedge clk);
      n++;
    end
    rd = rsp_rdata;
    chk(rsp_done && !ready_seen, "R9 ready low until done", {30'd0, rsp_done, ready_seen}, 32'h2);
    chk(addr_word == {8'h00, wr, idx[6:0]}, "R1 index value and write flag",
        {16'd0, addr_word}, {16'd0, 8'h00, wr, idx[6:0]});
    chk(data_cnt == (wide ? 2 : 1), wide ? "R3 two data strobes" : "R2 one data strobe",
        data_cnt, wide ? 2 : 1);
    @(negedge clk);
    chk(!rsp_done, "R9 done is one cycle", {31'd0, rsp_done}, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] rd;
    logic [31:0] w32;
    logic [15:0] w16;
    for (int i = 0; i < 128; i++) regs[i] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    req_index = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    chk(req_ready, "R10 ready after reset", {31'd0, req_ready}, 1);
    chk(!rsp_done && !pb_addr_sel && !pb_data_sel && !pb_rd && !pb_wr,
        "R10 quiet outputs after reset",
        {27'd0, rsp_done, pb_addr_sel, pb_data_sel, pb_rd, pb_wr}, 0);

    for (int i = 0; i < 128; i++) begin
      logic [7:0] idx;
      idx = 8'(i);
      w32 = {8'(i * 3 + 1), ~idx, idx ^ 8'h5A, 8'(i * 7 + 9)};
      w16 = 16'(i * 257) ^ 16'hC33C;

      xfer(1'b1, 1'b1, idx, w32, rd);
      chk(regs[i] == w32, "R3 low half first then high half", regs[i], w32);

      xfer(1'b0, 1'b1, idx, 32'hFFFF_FFFF, rd);
      chk(rd == w32, "R4 32-bit read assembly", rd, w32);

      xfer(1'b1, 1'b0, idx, {16'hDEAD, w16}, rd);
      chk(regs[i] == {w32[31:16], w16}, "R2 16-bit write touches low half only",
          regs[i], {w32[31:16], w16});

      xfer(1'b0, 1'b0, idx, 32'hFFFF_FFFF, rd);
      chk(rd == {16'h0000, w16}, "R4 16-bit read upper zero", rd, {16'h0000, w16});
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule